// File: doc/BRIEF.md
# Burst Capture Writer

This block streams a run of 128-bit samples into the command port of an external memory, one sample per clock, until a fixed number of samples has been captured. The sample is normally built from four parallel 32-bit lanes, for example four spectral power streams. A capture counter sets the position of each sample. When it reaches its last value it returns to zero and stays frozen there, so no further writes go out until the block is reset.

The memory port writes two consecutive physical locations while one command address is held for two cycles. Command address A covers physical locations 2A and 2A+1. The block therefore drops the counter's least significant bit to form the address. Each address is then presented on two consecutive commands, and every sample lands in its own physical location with none lost or duplicated. The 144-bit command word has two pad bytes, which are always driven to zero.

Software starts or pauses the capture with an enable input and restarts it with a synchronous reset. The done output reports that the whole burst has been issued.

Top module: `burst_capture_writer`

## Requirements
- R1: While reset is high at a clock edge, the following edge-registered outputs are all zero after that edge: cmdValid, done, cmdAddr and cmdData.
- R2: In every command word, bits [143:136] and [71:64] are zero. Sample bits [127:64] appear at [135:72], and sample bits [63:0] appear at [63:0]. Lane k of the input occupies sample bits [32k+31:32k].
- R3: A sample presented while enable is high, before the freeze, appears on cmdData with cmdValid high in the cycle after the clock edge that captured it.
- R4: The command for sample index n (counted from 0 since reset) carries cmdAddr = n >> 1. Address A therefore appears on the two commands for samples 2A and 2A+1.
- R5: While enable is low, no command is issued and the sample index holds. The next enabled sample continues with the following index.
- R6: After FINAL_COUNT commands have been issued, cmdValid stays low even while enable is high, until reset.
- R7: done rises in the cycle after the last command and stays high until reset.
- R8: A reset after a completed burst restarts the capture at sample index 0, so the first new command carries address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Capture enable |
| lanesIn | input | 128 | Sample: four 32-bit lanes, lane 0 in the low bits |
| cmdAddr | output | 24 | Memory command address |
| cmdData | output | 144 | Memory command word with two zero pad bytes |
| cmdValid | output | 1 | Command strobe |
| done | output | 1 | Burst complete |

## Verification
The burst is first driven with counting lane values, then with all-ones samples, then with pseudo-random samples. The all-ones pattern shows any leak into the pad bytes. The counting and random patterns show a lane or half swapped, or data from the wrong cycle. Enable is toggled every other cycle, which separates a counter that holds while paused from one that keeps moving, and exposes an address pairing that slips. Enable is kept high past the final count and a second burst follows a reset, which tests the freeze, the stickiness of done and the restart at address 0.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  localparam int SEG_W = 64;
  localparam int PAD_W = 8;

  typedef struct packed {
    logic issue;
    logic lastSample;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcw_ctrl.sv
module bcw_ctrl
  import bcw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FINAL_COUNT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  output ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] cmdIdx,
  output logic              done
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FINAL_COUNT - 1);

  logic [CNT_W-1:0] sampleCnt;
  logic             frozen;
  logic             doneReg;

  always_comb begin
    strobes.issue      = enable && !frozen;
    strobes.lastSample = (sampleCnt == LAST_IDX);
  end

  assign cmdIdx = sampleCnt[CNT_W-1:1];
  assign done   = doneReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
      frozen    <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= doneReg | frozen;
      if (strobes.issue) begin
        if (strobes.lastSample) begin
          sampleCnt <= '0;
          frozen    <= 1'b1;
        end else begin
          sampleCnt <= sampleCnt + 1'b1;
        end
      end
    end
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(sampleCnt));

  // R6
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frozen |=> frozen && sampleCnt == '0);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    doneReg |=> doneReg);
endmodule

// File: rtl/bcw_datapath.sv
module bcw_datapath
  import bcw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAYLOAD_W = 128,
  localparam int SEGS = PAYLOAD_W / SEG_W,
  localparam int CMD_W = SEGS * (SEG_W + PAD_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    cmdIdx,
  input  logic [PAYLOAD_W-1:0] sample,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [CMD_W-1:0]     cmdData,
  output logic                 cmdValid
);
  logic [CMD_W-1:0] packedWord;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    assign packedWord[s*(SEG_W+PAD_W) +: (SEG_W+PAD_W)] =
      {{PAD_W{1'b0}}, sample[s*SEG_W +: SEG_W]};

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
      cmdValid |-> cmdData[s*(SEG_W+PAD_W)+SEG_W +: PAD_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdAddr  <= '0;
      cmdData  <= '0;
      cmdValid <= 1'b0;
    end else begin
      cmdValid <= strobes.issue;
      if (strobes.issue) begin
        cmdAddr <= cmdIdx;
        cmdData <= packedWord;
      end
    end
  end

  // R3
  issue_latency_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.issue |=> cmdValid);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid && $past(cmdValid) |->
      (cmdAddr == $past(cmdAddr) || cmdAddr == $past(cmdAddr) + 1'b1 || cmdAddr == '0));
endmodule

// File: rtl/burst_capture_writer.sv
module burst_capture_writer
  import bcw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 32,
  parameter int LANES = 4,
  parameter int FINAL_COUNT = 1024,
  localparam int PAYLOAD_W = LANE_W * LANES,
  localparam int CMD_W = (PAYLOAD_W / SEG_W) * (SEG_W + PAD_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [PAYLOAD_W-1:0] lanesIn,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [CMD_W-1:0]     cmdData,
  output logic                 cmdValid,
  output logic                 done
);
  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] cmdIdx;

  bcw_ctrl #(.ADDR_W(ADDR_W), .FINAL_COUNT(FINAL_COUNT)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable),
    .strobes(strobes), .cmdIdx(cmdIdx), .done(done)
  );

  bcw_datapath #(.ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .cmdIdx(cmdIdx),
    .sample(lanesIn), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdValid(cmdValid)
  );

  // R6
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmdValid);

  // R5
  paused_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !cmdValid);
endmodule

// File: tb/tb_burst_capture_writer.sv
module tb_burst_capture_writer;
  localparam int FINAL = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic [127:0] lanesIn = '0;
  logic [23:0]  cmdAddr;
  logic [143:0] cmdData;
  logic         cmdValid;
  logic         done;

  burst_capture_writer #(.FINAL_COUNT(FINAL)) dut (
    .clk(clk), .rst(rst), .enable(enable), .lanesIn(lanesIn),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdValid(cmdValid), .done(done)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit           rstv;
    bit           valid;
    bit           first;
    bit           done;
    logic [23:0]  addr;
    logic [143:0] data;
    string        idleTag;
  } exp_t;

  exp_t expQ[$];
  int   errors = 0;
  int   checks = 0;
  int   idxM = 0;
  bit   frozenM = 0;
  bit   doneM = 0;
  bit   firstM = 1;

  task automatic check(bit ok, string tag, logic [143:0] act, logic [143:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(bit en, logic [127:0] s, bit r);
    exp_t e;
    @(negedge clk);
    rst = r; enable = en; lanesIn = s;
    e.rstv = r; e.valid = 0; e.first = 0; e.done = 0;
    e.addr = '0; e.data = '0; e.idleTag = "R5";
    if (r) begin
      idxM = 0; frozenM = 0; doneM = 0; firstM = 1;
    end else begin
      e.done = doneM | frozenM;
      doneM = e.done;
      if (frozenM) e.idleTag = "R6";
      if (en && !frozenM) begin
        e.valid = 1;
        e.addr  = 24'(idxM >> 1);
        e.data  = {8'h00, s[127:64], 8'h00, s[63:0]};
        e.first = firstM;
        firstM  = 0;
        idxM++;
        if (idxM == FINAL) begin
          idxM = 0; frozenM = 1;
        end
      end
    end
    expQ.push_back(e);
  endtask

  function automatic logic [127:0] countLanes(int base);
    return {32'(base + 3), 32'(base + 2), 32'(base + 1), 32'(base)};
  endfunction

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        if (e.rstv) begin
          check(cmdValid == 0 && done == 0 && cmdAddr == 0 && cmdData == 0,
                "R1 reset outputs", {cmdValid, done, cmdAddr, cmdData[117:0]}, '0);
        end else begin
          check(cmdValid == e.valid, e.valid ? "R3 valid" : e.idleTag,
                144'(cmdValid), 144'(e.valid));
          check(done == e.done, "R7 done", 144'(done), 144'(e.done));
          if (e.valid && cmdValid) begin
            check(cmdAddr == e.addr, e.first ? "R8 restart addr" : "R4 addr",
                  144'(cmdAddr), 144'(e.addr));
            check(cmdData == e.data, "R3 data", cmdData, e.data);
            check(cmdData[143:136] == 0 && cmdData[71:64] == 0, "R2 pad bytes",
                  144'({cmdData[143:136], cmdData[71:64]}), '0);
          end
        end
      end
    end
  end

  task automatic finishUp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishUp();
  end

  initial begin : driver
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, countLanes(100 + i), 1);
    // R3/R4: counting lanes, continuous
    for (int i = 0; i < 5; i++) step(1, countLanes(16 * i), 0);
    // R5: pause
    for (int i = 0; i < 3; i++) step(0, countLanes(900 + i), 0);
    // R2: all ones
    for (int i = 0; i < 3; i++) step(1, '1, 0);
    // R5: alternate enable
    for (int i = 0; i < 6; i++) step(i[0], countLanes(500 + 7 * i), 0);
    // R6/R7: run past the final count
    for (int i = 0; i < 10; i++) step(1, countLanes(2000 + i), 0);
    // R8: restart after reset, random samples
    step(1, '1, 1);
    for (int i = 0; i < FINAL + 4; i++)
      step(1, {$urandom(), $urandom(), $urandom(), $urandom()}, 0);
    step(0, '0, 0);
    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R3 queue drained", 144'(expQ.size()), '0);
    finishUp();
  end
endmodule